// File: doc/BRIEF.md
# Flash Write-Buffer Command Interpreter

This block is the device-side command decoder for buffered programming of a flash memory, modelled at the synchronous register level. A host drives bus writes and reads (address, data, write and read strobes) on a single clock. A buffered program follows a fixed grammar. The host sends a start command, then a word count, then the data words, then a confirm. The block keeps the words and their addresses in a buffer of up to 32 entries. It latches the block address given with the start command and holds a status register with sticky error flags.

Reads return one of three things, depending on the command mode: array contents, an extended status word, or the status register. After a valid confirm the block stays busy for a parameterised number of cycles. During that time it copies the buffered words, one per cycle, into a small internal array. It then reports ready. A broken grammar cancels the sequence and raises the improper-sequence flags. There are three kinds of break: a count that is too large, an address outside the latched block, or a wrong confirm value. Separate commands clear the flags and return the block to array reads.

Top module: `flash_wb_cmd`

## Requirements
- R1: After reset the block is in array-read mode, every array word is 0, `rdata` is 0, and the status word reads 0x0080 (ready, no error flags).
- R2: In array or status mode, a write whose low byte is 0xE8 latches the block number `addr[ADDR_W-1:BLK_BITS]` and enters count mode. A read in count mode returns the extended status 0x0080 (bit 7 = buffer available).
- R3: In count mode the next write gives N in `wdata`, meaning N+1 words. N from 0 to 31 is accepted. N above 31 cancels the sequence.
- R4: The next N+1 writes are data words, each stored together with its own address. If the count write or any data write has an address outside the latched block, the sequence is cancelled and the array is not changed.
- R5: After the last data word, a write with low byte 0xD0 starts programming. Any other value cancels the sequence and leaves the array unchanged.
- R6: A cancelled sequence sets status bits 5 and 4 and leaves the block in status mode. The bits stay set through later successful programs until they are cleared.
- R7: After a confirm, status bit 7 reads 0 for exactly BUSY_CYCLES read cycles and then 1. Every write during this busy period is ignored.
- R8: When programming completes, each buffered word is in the array at the address it was written with. All other array words are unchanged.
- R9: After a confirm, and after a cancelled sequence, reads return the status register: bit 7 ready, bit 5 and bit 4 error, all other bits 0.
- R10: A write with low byte 0xFF in array or status mode selects array-read mode, and reads then return the array word at `addr`.
- R11: A write with low byte 0x50 in array or status mode clears status bits 5 and 4 and does not change the mode.
- R12: `rdata` is registered. It shows the result of a read on the clock edge after `rd_en` is sampled high and holds its value while `rd_en` is low.
- R13: In array or status mode, a write of any other command value changes neither the array, the mode nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data: command, count or buffer word |
| rdata | output | DATA_W | Registered read data |

## Verification
Programming is tried with a full 32-word buffer and with a single-word buffer. The full buffer covers the top of the count range and shows that the busy length is independent of the word count. The single word covers N = 0 and shows that no neighbouring word is written. Cancellation is driven by four distinct patterns: a count above range, a count written to a foreign block, a data word in a foreign block, and a wrong confirm value. Each is followed by array read-back, which separates a clean cancel from one that leaks buffer contents into the array. Command writes during busy, and unknown commands at rest, are checked at a programmed address where array data and status words differ.

// File: rtl/flash_wb_pkg.sv
package flash_wb_pkg;

    typedef enum logic [2:0] {
        M_ARRAY   = 3'd0,
        M_COUNT   = 3'd1,
        M_LOAD    = 3'd2,
        M_CONFIRM = 3'd3,
        M_BUSY    = 3'd4,
        M_STATUS  = 3'd5
    } fwb_mode_e;

    localparam logic [7:0] CMD_BUF_START = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_READ_ARR  = 8'hFF;
    localparam logic [7:0] CMD_CLR_ERR   = 8'h50;

    localparam int ST_READY_BIT = 7;
    localparam int ST_SEQ_BIT   = 5;
    localparam int ST_PRG_BIT   = 4;

endpackage

// File: rtl/fwb_buffer.sv
module fwb_buffer #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q [BUF_DEPTH];
    logic [DATA_W-1:0] data_q [BUF_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else if (we) begin
            addr_q[widx] <= waddr;
            data_q[widx] <= wdata;
        end
    end

    assign raddr = addr_q[ridx];
    assign rdata = data_q[ridx];

endmodule

// File: rtl/fwb_array.sv
module fwb_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cell_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                cell_q[i] <= '0;
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
    import flash_wb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int BUF_DEPTH   = 32,
    parameter int BLK_BITS    = 5,
    parameter int BUSY_CYCLES = 40,
    localparam int IDX_W      = $clog2(BUF_DEPTH),
    localparam int BLK_W      = ADDR_W - BLK_BITS,
    localparam int BSY_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output fwb_mode_e         mode_o,
    output logic [1:0]        err_o,
    output logic [IDX_W-1:0]  cnt_o,
    output logic [IDX_W-1:0]  load_idx_o,
    output logic [BSY_W-1:0]  busy_left_o,
    output logic              buf_we_o,
    output logic              commit_we_o,
    output logic [IDX_W-1:0]  commit_idx_o
);

    typedef struct packed {
        fwb_mode_e        mode;
        logic [BLK_W-1:0] blk;
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [IDX_W:0]   ci;
        logic [BSY_W-1:0] busy;
        logic [1:0]       err;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [BLK_W-1:0] blk_in;
    logic [7:0]       cmd;
    logic             blk_miss;
    logic             cnt_bad;
    logic             commit_we;

    assign blk_in   = addr[ADDR_W-1:BLK_BITS];
    assign cmd      = wdata[7:0];
    assign blk_miss = (blk_in != s_q.blk);
    assign cnt_bad  = (wdata > DATA_W'(BUF_DEPTH - 1));

    always_comb begin
        s_d       = s_q;
        buf_we_o  = 1'b0;
        commit_we = 1'b0;
        unique case (s_q.mode)
            M_ARRAY, M_STATUS: begin
                if (wr_en) begin
                    if (cmd == CMD_BUF_START) begin
                        s_d.mode = M_COUNT;
                        s_d.blk  = blk_in;
                    end else if (cmd == CMD_READ_ARR) begin
                        s_d.mode = M_ARRAY;
                    end else if (cmd == CMD_CLR_ERR) begin
                        s_d.err = 2'b00;
                    end
                end
            end
            M_COUNT: begin
                if (wr_en) begin
                    if (blk_miss || cnt_bad) begin
                        s_d.mode = M_STATUS;
                        s_d.err  = 2'b11;
                    end else begin
                        s_d.cnt  = wdata[IDX_W-1:0];
                        s_d.idx  = '0;
                        s_d.mode = M_LOAD;
                    end
                end
            end
            M_LOAD: begin
                if (wr_en) begin
                    if (blk_miss) begin
                        s_d.mode = M_STATUS;
                        s_d.err  = 2'b11;
                    end else begin
                        buf_we_o = 1'b1;
                        if (s_q.idx == s_q.cnt) begin
                            s_d.mode = M_CONFIRM;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end
                end
            end
            M_CONFIRM: begin
                if (wr_en) begin
                    if (cmd == CMD_CONFIRM) begin
                        s_d.mode = M_BUSY;
                        s_d.busy = BSY_W'(BUSY_CYCLES - 1);
                        s_d.ci   = '0;
                    end else begin
                        s_d.mode = M_STATUS;
                        s_d.err  = 2'b11;
                    end
                end
            end
            M_BUSY: begin
                commit_we = (s_q.ci <= {1'b0, s_q.cnt});
                if (commit_we) begin
                    s_d.ci = s_q.ci + 1'b1;
                end
                if (s_q.busy == '0) begin
                    s_d.mode = M_STATUS;
                end else begin
                    s_d.busy = s_q.busy - 1'b1;
                end
            end
            default: begin
                s_d.mode = M_ARRAY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: M_ARRAY, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o       = s_q.mode;
    assign err_o        = s_q.err;
    assign cnt_o        = s_q.cnt;
    assign load_idx_o   = s_q.idx;
    assign busy_left_o  = s_q.busy;
    assign commit_we_o  = commit_we;
    assign commit_idx_o = s_q.ci[IDX_W-1:0];

endmodule

// File: rtl/flash_wb_cmd.sv
module flash_wb_cmd
    import flash_wb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int BUF_DEPTH   = 32,
    parameter int BLK_BITS    = 5,
    parameter int BUSY_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam int BSY_W = $clog2(BUSY_CYCLES + 1);

    if (BUSY_CYCLES < BUF_DEPTH) begin : g_bad_busy
        $error("BUSY_CYCLES must cover one commit cycle per buffer entry");
    end
    if (BLK_BITS >= ADDR_W) begin : g_bad_blk
        $error("BLK_BITS must leave at least one block number bit");
    end

    fwb_mode_e         mode;
    logic [1:0]        err_bits;
    logic [IDX_W-1:0]  load_cnt;
    logic [IDX_W-1:0]  load_idx;
    logic [BSY_W-1:0]  busy_left;
    logic              buf_we;
    logic              commit_we;
    logic [IDX_W-1:0]  commit_idx;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [7:0]        status_byte;

    fwb_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH),
        .BLK_BITS(BLK_BITS), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode_o(mode), .err_o(err_bits), .cnt_o(load_cnt),
        .load_idx_o(load_idx), .busy_left_o(busy_left),
        .buf_we_o(buf_we), .commit_we_o(commit_we), .commit_idx_o(commit_idx)
    );

    fwb_buffer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .widx(load_idx),
        .waddr(addr), .wdata(wdata), .ridx(commit_idx),
        .raddr(commit_addr), .rdata(commit_data)
    );

    fwb_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .we(commit_we), .waddr(commit_addr),
        .wdata(commit_data), .raddr(addr), .rdata(arr_word)
    );

    always_comb begin
        status_byte               = 8'h00;
        status_byte[ST_READY_BIT] = (mode != M_BUSY);
        status_byte[ST_SEQ_BIT]   = err_bits[1];
        status_byte[ST_PRG_BIT]   = err_bits[0];
        rdata_d = rdata_q;
        if (rd_en) begin
            unique case (mode)
                M_ARRAY: rdata_d = arr_word;
                M_COUNT: rdata_d = DATA_W'(8'h80);
                default: rdata_d = DATA_W'(status_byte);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/fwb_checker.sv
module fwb_checker
    import flash_wb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5,
    parameter int BSY_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input fwb_mode_e         mode,
    input logic [1:0]        err_bits,
    input logic [IDX_W-1:0]  load_cnt,
    input logic [IDX_W-1:0]  load_idx,
    input logic [BSY_W-1:0]  busy_left,
    input logic              commit_we
);

    p_cancel_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_COUNT || mode == M_LOAD || mode == M_CONFIRM) && wr_en)
        |=> (mode != M_STATUS || err_bits == 2'b11));

    p_sticky_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits == 2'b11 && !(wr_en && wdata[7:0] == CMD_CLR_ERR))
        |=> (err_bits == 2'b11));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_ARRAY || mode == M_STATUS) && wr_en && wdata[7:0] == CMD_CLR_ERR)
        |=> (err_bits == 2'b00 && $stable(mode)));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BUSY && busy_left != '0) |=> (mode == M_BUSY));

    p_busy_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BUSY) |=> (mode == M_BUSY || mode == M_STATUS));

    p_commit_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |-> (mode == M_BUSY));

    p_load_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_LOAD) |-> (load_idx <= load_cnt));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind flash_wb_cmd fwb_checker #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .BSY_W(BSY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .mode(mode), .err_bits(err_bits),
    .load_cnt(load_cnt), .load_idx(load_idx), .busy_left(busy_left),
    .commit_we(commit_we)
);

// File: tb/sim_flash_wb_cmd.sv
`timescale 1ns/1ps
module sim_flash_wb_cmd;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int BUSY   = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flash_wb_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_ready(output int busy_reads);
        busy_reads = 0;
        rd_en = 1'b1; addr = 8'h00;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (rdata[7]) break;
            busy_reads++;
        end
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        chk("R1 rdata after reset", rdata, 16'h0000);
        bus_rd(8'h05, v);
        chk("R1 array word zero", v, 16'h0000);
        bus_wr(8'h00, 16'h0050);
        bus_rd(8'h05, v);
        chk("R1 array mode kept", v, 16'h0000);
    endtask

    task automatic t_full_program();
        logic [DATA_W-1:0] v;
        int n;
        bus_wr(8'h40, 16'h00E8);
        bus_rd(8'h40, v);
        chk("R2 extended status", v, 16'h0080);
        bus_wr(8'h40, 16'd31);
        for (int i = 0; i < 32; i++) bus_wr(8'h40 + 8'(i), 16'hA000 + 16'(i));
        bus_wr(8'h40, 16'h00D0);
        wait_ready(n);
        chk("R7 busy read count", 16'(n), 16'(BUSY));
        bus_rd(8'h40, v);
        chk("R9 status after confirm", v, 16'h0080);
        bus_wr(8'h00, 16'h00FF);
        for (int i = 0; i < 32; i++) begin
            bus_rd(8'h40 + 8'(i), v);
            chk("R8 R10 programmed word", v, 16'hA000 + 16'(i));
        end
        bus_rd(8'h3F, v);
        chk("R8 neighbour below", v, 16'h0000);
        bus_rd(8'h60, v);
        chk("R8 neighbour above", v, 16'h0000);
    endtask

    task automatic t_single_busy_ignore();
        logic [DATA_W-1:0] v;
        int n;
        bus_wr(8'h80, 16'h00E8);
        bus_wr(8'h80, 16'd0);
        bus_wr(8'h85, 16'h1234);
        bus_wr(8'h80, 16'h00D0);
        bus_wr(8'h40, 16'h00FF);
        bus_wr(8'h40, 16'h00E8);
        bus_rd(8'h40, v);
        chk("R7 writes ignored while busy", v, 16'h0000);
        wait_ready(n);
        bus_rd(8'h40, v);
        chk("R7 ready after busy", v, 16'h0080);
        bus_wr(8'h00, 16'h00FF);
        bus_rd(8'h85, v);
        chk("R3 single word", v, 16'h1234);
        bus_rd(8'h86, v);
        chk("R8 no extra word", v, 16'h0000);
    endtask

    task automatic t_cancel_block();
        logic [DATA_W-1:0] v;
        bus_wr(8'h40, 16'h00E8);
        bus_wr(8'h40, 16'd3);
        bus_wr(8'h40, 16'h5555);
        bus_wr(8'h60, 16'h6666);
        bus_rd(8'h40, v);
        chk("R4 R6 data outside block", v, 16'h00B0);
        bus_wr(8'h00, 16'h0050);
        bus_rd(8'h40, v);
        chk("R11 cleared", v, 16'h0080);
        bus_wr(8'h00, 16'h00FF);
        bus_rd(8'h40, v);
        chk("R4 array untouched", v, 16'hA000);
        bus_wr(8'h40, 16'h00E8);
        bus_wr(8'h80, 16'd0);
        bus_rd(8'h40, v);
        chk("R4 count outside block", v, 16'h00B0);
        bus_wr(8'h00, 16'h0050);
    endtask

    task automatic t_cancel_count();
        logic [DATA_W-1:0] v;
        bus_wr(8'h40, 16'h00E8);
        bus_wr(8'h40, 16'h0020);
        bus_rd(8'h40, v);
        chk("R3 count above range", v, 16'h00B0);
        bus_wr(8'h00, 16'h0050);
    endtask

    task automatic t_cancel_confirm();
        logic [DATA_W-1:0] v;
        int n;
        bus_wr(8'h40, 16'h00E8);
        bus_wr(8'h40, 16'd1);
        bus_wr(8'h41, 16'h7777);
        bus_wr(8'h42, 16'h8888);
        bus_wr(8'h40, 16'h0077);
        bus_rd(8'h40, v);
        chk("R5 wrong confirm", v, 16'h00B0);
        bus_wr(8'hC0, 16'h00E8);
        bus_wr(8'hC0, 16'd0);
        bus_wr(8'hC3, 16'h4321);
        bus_wr(8'hC0, 16'h00D0);
        wait_ready(n);
        bus_rd(8'h40, v);
        chk("R6 flags sticky", v, 16'h00B0);
        bus_wr(8'h00, 16'h0050);
        bus_rd(8'h40, v);
        chk("R11 clear keeps status mode", v, 16'h0080);
        bus_wr(8'h00, 16'h00FF);
        bus_rd(8'h41, v);
        chk("R5 array untouched", v, 16'hA001);
        bus_rd(8'hC3, v);
        chk("R8 later program", v, 16'h4321);
    endtask

    task automatic t_ignore_hold();
        logic [DATA_W-1:0] v;
        bus_wr(8'h40, 16'h0012);
        bus_rd(8'h40, v);
        chk("R13 unknown command", v, 16'hA000);
        addr = 8'h41;
        repeat (3) @(negedge clk);
        chk("R12 rdata held", rdata, 16'hA000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_program();
        t_single_busy_ignore();
        t_cancel_block();
        t_cancel_count();
        t_cancel_confirm();
        t_ignore_hold();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule